// File: doc/BRIEF.md
# Sub-Dword Operand Select and Merge

This block prepares two 32-bit integer operands and writes back their sum into part of a destination word. Each source carries its own field select. The select narrows the source to one byte or one half-word, which is moved down to bit 0, or it passes the whole word. A narrowed source is zero-extended by default. A per-source flag asks for sign extension instead.

The two prepared operands are added modulo 2^32. The low bits of the sum then go into a field of the destination that is chosen independently of the source fields. A policy code decides what the destination bits outside that field become:
- preserve: they are copied from the old destination value.
- zero: they are cleared.
- sign: the bits above the field repeat the field's top bit, and the bits below it are cleared.

The merged word is registered, so it appears one clock after a valid input.

Top module: `sdsel_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_data` is 0 until the first valid input.
- R2: `out_valid` is `in_valid` delayed by one clock. `out_data` is updated only on a clock where `in_valid` is 1 and otherwise holds its value.
- R3: Field select codes are: 0 whole word; 1 bits 7:0; 2 bits 15:8; 3 bits 23:16; 4 bits 31:24; 5 bits 15:0; 6 bits 31:16. A selected source field is shifted down to bit 0.
- R4: A narrowed source whose sign flag is 0 is zero-extended to 32 bits.
- R5: A narrowed source whose sign flag is 1 is sign-extended from the field's top bit. The sign flag has no effect on a whole-word source.
- R6: The result is the sum of the two prepared operands modulo 2^32, and any carry out is discarded.
- R7: When the destination select is the whole word, `out_data` is the sum, whatever the policy and the old destination value.
- R8: Policy code 1 (zero) clears every destination bit outside the selected field.
- R9: Policy code 2 (sign) fills the bits above the field with the field's top bit and clears the bits below the field.
- R10: Policy code 0 (preserve, the default) takes the bits outside the field from `old_dst`. The unused policy code 3 behaves as preserve.
- R11: The unused select code 7 behaves as the whole word, both on a source and on the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation is valid |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| old_dst | input | 32 | Previous destination value, used by the preserve policy |
| sel_a | input | 3 | Field select for `src_a` |
| sel_b | input | 3 | Field select for `src_b` |
| sel_dst | input | 3 | Destination field select |
| sext_a | input | 1 | Sign-extend the `src_a` field |
| sext_b | input | 1 | Sign-extend the `src_b` field |
| dst_policy | input | 2 | Policy for the unselected destination bits |
| out_valid | output | 1 | Registered valid |
| out_data | output | 32 | Registered merged word |

## Verification
The bench targets fields whose top bit is 1 under both extension choices. A design that mixes up sign and zero extension returns a large positive or negative value where the other is expected. It exercises the sign policy with a byte or half-word in the middle of the word. A design that fills below the field, or fills from bit 31 of the sum instead of the field's top bit, corrupts the low or high bits. It also drives sums that overflow 32 bits, the unused select and policy codes, and clocks with `in_valid` low while the inputs change. A design that drops those codes into another mode, or that updates on an idle cycle, gives a visibly wrong merged word.

// File: rtl/sdsel_pkg.sv
package sdsel_pkg;

    typedef enum logic [2:0] {
        FLD_WORD  = 3'd0,
        FLD_BYTE0 = 3'd1,
        FLD_BYTE1 = 3'd2,
        FLD_BYTE2 = 3'd3,
        FLD_BYTE3 = 3'd4,
        FLD_HALF0 = 3'd5,
        FLD_HALF1 = 3'd6,
        FLD_SPARE = 3'd7
    } fld_e;

    typedef enum logic [1:0] {
        POL_KEEP  = 2'd0,
        POL_ZERO  = 2'd1,
        POL_SIGN  = 2'd2,
        POL_SPARE = 2'd3
    } pol_e;

    typedef struct packed {
        logic [7:0] lsb;
        logic [7:0] wid;
        logic       whole;
    } fld_geom_t;

    // Position and width of a field; the unused code falls back to the whole word.
    function automatic fld_geom_t fld_geom(fld_e f, int dw, int bw);
        fld_geom_t g;
        g.whole = 1'b0;
        g.lsb   = 8'd0;
        g.wid   = 8'(bw);
        unique case (f)
            FLD_BYTE0: g.lsb = 8'd0;
            FLD_BYTE1: g.lsb = 8'(bw);
            FLD_BYTE2: g.lsb = 8'(2 * bw);
            FLD_BYTE3: g.lsb = 8'(3 * bw);
            FLD_HALF0: begin g.lsb = 8'd0;      g.wid = 8'(2 * bw); end
            FLD_HALF1: begin g.lsb = 8'(2 * bw); g.wid = 8'(2 * bw); end
            default:   begin g.whole = 1'b1;   g.wid = 8'(dw);     end
        endcase
        return g;
    endfunction

endpackage

// File: rtl/sdsel_extract.sv
module sdsel_extract
    import sdsel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] src,
    input  fld_e              sel,
    input  logic              sext,
    output logic [DATA_W-1:0] opnd
);

    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    fld_geom_t         geom;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] fmask;
    logic [DATA_W-1:0] field;
    logic              top;

    always_comb begin
        geom    = fld_geom(sel, DATA_W, BYTE_W);
        shifted = src >> geom.lsb;
        fmask   = ONES >> (8'(DATA_W) - geom.wid);
        field   = shifted & fmask;
        top     = shifted[geom.wid - 8'd1];
        if (geom.whole) begin
            opnd = src;
        end else if (sext && top) begin
            opnd = field | ~fmask;
        end else begin
            opnd = field;
        end
    end

endmodule

// File: rtl/sdsel_merge.sv
module sdsel_merge
    import sdsel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] sum,
    input  logic [DATA_W-1:0] old_val,
    input  fld_e              sel,
    input  pol_e              policy,
    output logic [DATA_W-1:0] merged
);

    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    fld_geom_t         geom;
    logic [DATA_W-1:0] fmask;
    logic [DATA_W-1:0] in_field;
    logic [DATA_W-1:0] below;
    logic [DATA_W-1:0] above;
    logic [DATA_W-1:0] placed;
    logic              top;

    always_comb begin
        geom     = fld_geom(sel, DATA_W, BYTE_W);
        fmask    = ONES >> (8'(DATA_W) - geom.wid);
        in_field = fmask << geom.lsb;
        below    = ONES >> (8'(DATA_W) - geom.lsb);
        above    = ~(in_field | below);
        placed   = (sum << geom.lsb) & in_field;
        top      = sum[geom.wid - 8'd1];
        if (geom.whole) begin
            merged = sum;
        end else begin
            unique case (policy)
                POL_ZERO: merged = placed;
                POL_SIGN: merged = placed | (top ? above : '0);
                default:  merged = placed | (old_val & ~in_field);
            endcase
        end
    end

endmodule

// File: rtl/sdsel_unit.sv
module sdsel_unit
    import sdsel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] old_dst,
    input  logic [2:0]        sel_a,
    input  logic [2:0]        sel_b,
    input  logic [2:0]        sel_dst,
    input  logic              sext_a,
    input  logic              sext_b,
    input  logic [1:0]        dst_policy,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int NUM_SRC = 2;
    localparam int HALF_W  = 2 * BYTE_W;

    logic [DATA_W-1:0] src_vec  [NUM_SRC];
    fld_e              sel_vec  [NUM_SRC];
    logic              sext_vec [NUM_SRC];
    logic [DATA_W-1:0] opnd_vec [NUM_SRC];
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] merged;

    assign src_vec[0]  = src_a;
    assign src_vec[1]  = src_b;
    assign sel_vec[0]  = fld_e'(sel_a);
    assign sel_vec[1]  = fld_e'(sel_b);
    assign sext_vec[0] = sext_a;
    assign sext_vec[1] = sext_b;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        sdsel_extract #(
            .DATA_W (DATA_W),
            .BYTE_W (BYTE_W)
        ) u_extract (
            .src  (src_vec[k]),
            .sel  (sel_vec[k]),
            .sext (sext_vec[k]),
            .opnd (opnd_vec[k])
        );
    end

    assign sum = opnd_vec[0] + opnd_vec[1];

    sdsel_merge #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_merge (
        .sum     (sum),
        .old_val (old_dst),
        .sel     (fld_e'(sel_dst)),
        .policy  (pol_e'(dst_policy)),
        .merged  (merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= merged;
            end
        end
    end

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R10
    keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_policy == 2'd0 && sel_dst == 3'd1)
        |=> out_data[DATA_W-1:BYTE_W] == $past(old_dst[DATA_W-1:BYTE_W]));

    // R8
    zero_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_policy == 2'd1 && sel_dst == 3'd5)
        |=> out_data[DATA_W-1:HALF_W] == '0);

    // R7
    whole_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_dst == 3'd0 && sel_a == 3'd0 && sel_b == 3'd0)
        |=> out_data == $past(src_a + src_b));

endmodule

// File: tb/sdsel_unit_test.sv
`timescale 1ns/1ps
module sdsel_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_a = '0, src_b = '0, old_dst = '0;
    logic [2:0]  sel_a = '0, sel_b = '0, sel_dst = '0;
    logic        sext_a = 1'b0, sext_b = 1'b0;
    logic [1:0]  dst_policy = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    sdsel_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .sel_a(sel_a), .sel_b(sel_b), .sel_dst(sel_dst),
        .sext_a(sext_a), .sext_b(sext_b), .dst_policy(dst_policy),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int fld_lo(logic [2:0] s);
        case (s)
            3'd2: return 8;
            3'd3: return 16;
            3'd4: return 24;
            3'd6: return 16;
            default: return 0;
        endcase
    endfunction

    function automatic int fld_len(logic [2:0] s);
        case (s)
            3'd1, 3'd2, 3'd3, 3'd4: return 8;
            3'd5, 3'd6: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] ref_opnd(logic [31:0] v, logic [2:0] s, logic se);
        logic [31:0] r = '0;
        int lo = fld_lo(s);
        int n = fld_len(s);
        if (n == 32) return v;
        for (int i = 0; i < 32; i++) begin
            if (i < n) r[i] = v[lo + i];
            else r[i] = se ? v[lo + n - 1] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_merge(logic [31:0] s, logic [31:0] od,
                                              logic [2:0] d, logic [1:0] p);
        logic [31:0] r = '0;
        int lo = fld_lo(d);
        int n = fld_len(d);
        if (n == 32) return s;
        for (int i = 0; i < 32; i++) begin
            if (i >= lo && i < lo + n) r[i] = s[i - lo];
            else if (p == 2'd1) r[i] = 1'b0;
            else if (p == 2'd2) r[i] = (i >= lo + n) ? s[n - 1] : 1'b0;
            else r[i] = od[i];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic run_op(string tag, logic [31:0] a, logic [31:0] b, logic [31:0] od,
                          logic [2:0] sa, logic [2:0] sb, logic [2:0] sd,
                          logic xa, logic xb, logic [1:0] p);
        logic [31:0] exp;
        @(negedge clk);
        src_a = a; src_b = b; old_dst = od;
        sel_a = sa; sel_b = sb; sel_dst = sd;
        sext_a = xa; sext_b = xb; dst_policy = p;
        in_valid = 1'b1;
        exp = ref_merge(ref_opnd(a, sa, xa) + ref_opnd(b, sb, xb), od, sd, p);
        @(negedge clk);
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, out_data, exp);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        int seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset data", out_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 idle valid", {31'd0, out_valid}, 32'd0);
        check("R1 idle data", out_data, 32'd0);

        // R3 R4: byte 2 zero-extended, half 1
        run_op("R3 R4 byte2", 32'h00A50000, 32'h0000_0001, 32'h0, 3'd3, 3'd0, 3'd0, 1'b0, 1'b0, 2'd0);
        run_op("R3 half1", 32'h8001_0000, 32'h0, 32'h0, 3'd6, 3'd0, 3'd0, 1'b0, 1'b0, 2'd0);
        // R5: sign-extended byte 3, no effect on whole word
        run_op("R5 byte3 sext", 32'hF000_0000, 32'h0, 32'h0, 3'd4, 3'd0, 3'd0, 1'b1, 1'b0, 2'd0);
        run_op("R5 whole sext", 32'h8000_0000, 32'h1, 32'h0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1, 2'd0);
        // R6: wrap-around
        run_op("R6 wrap", 32'hFFFF_FFFF, 32'h0000_0002, 32'h0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 2'd1);
        // R7: whole destination ignores policy and old value
        run_op("R7 whole dst", 32'h1234_5678, 32'h1, 32'hDEAD_BEEF, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 2'd2);
        // R8: zero policy on byte 1
        run_op("R8 zero byte1", 32'h0000_007F, 32'h1, 32'hFFFF_FFFF, 3'd1, 3'd1, 3'd2, 1'b0, 1'b0, 2'd1);
        // R9: sign policy on byte 1 with negative field -> upper ones, lower zero
        run_op("R9 sign byte1", 32'h0000_0080, 32'h0, 32'hFFFF_FFFF, 3'd1, 3'd0, 3'd2, 1'b0, 1'b0, 2'd2);
        check("R9 explicit", out_data, 32'hFFFF_8000);
        // R10: preserve and spare policy code
        run_op("R10 keep half0", 32'h0000_0005, 32'h0000_0003, 32'hCAFE_0000, 3'd5, 3'd5, 3'd5, 1'b0, 1'b0, 2'd0);
        check("R10 explicit", out_data, 32'hCAFE_0008);
        run_op("R10 spare pol", 32'h0000_0011, 32'h0, 32'hA5A5_A5A5, 3'd1, 3'd0, 3'd3, 1'b0, 1'b0, 2'd3);
        // R11: spare select code on source and destination
        run_op("R11 spare sel", 32'hF000_0001, 32'h1, 32'h5555_5555, 3'd7, 3'd7, 3'd7, 1'b1, 1'b1, 2'd1);
        check("R11 explicit", out_data, 32'hF000_0002);

        // R2: idle cycle with changed inputs holds data
        held = out_data;
        @(negedge clk);
        src_a = 32'h1111_1111; sel_dst = 3'd1; dst_policy = 2'd1;
        @(negedge clk);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);
        check("R2 idle hold", out_data, held);

        // random mix, tag by destination policy
        for (int n = 0; n < 400; n++) begin
            logic [2:0] sd = 3'($urandom_range(0, 7));
            logic [1:0] p = 2'($urandom_range(0, 3));
            string tag;
            if (sd == 3'd0 || sd == 3'd7) tag = "R7 R11 rand";
            else if (p == 2'd1) tag = "R8 rand";
            else if (p == 2'd2) tag = "R9 rand";
            else tag = "R10 rand";
            run_op(tag, $urandom, $urandom, $urandom,
                   3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), sd,
                   1'($urandom), 1'($urandom), p);
        end
        finish_run();
    end

endmodule